// File: doc/BRIEF.md
# Kick-Restart Watchdog Timer

A watchdog countdown timer with a small word-addressed register bus. Software picks one of sixteen power-of-two timeout periods, turns the timer on with a control bit that cannot be turned off again, and keeps the system alive by writing one exact restart word at regular intervals. If software stops doing so, the counter reaches zero. The block then either pulses a system reset output at once, or first raises an interrupt and pulses the reset only if the next period also runs out with no restart.

The live count can be read back at any time. Two period selects are kept. The initial select applies only to the first load, when the timer is switched on. The running select applies to every later reload. A parameter sets the base exponent of the periods, so that simulation can use short timeouts. A second parameter sets the length of the reset pulse. After the pulse the block stays off until its own reset is asserted.

Top module: `kick_watchdog`

## Requirements
- R1: After reset, `irq_o` and `sys_rst_o` are low, and reads of the control word (offset 0x0), the period word (offset 0x4) and the count (offset 0x8) all return 0.
- R2: A control write with bit 0 set, made while the timer is off, turns it on and loads the count with 2^(BASE_EXP+s)-1, where s is the initial select in bits [7:4] of the period word.
- R3: Once on, the timer stays on. Writing 0 to control bit 0 leaves it on, and the enable clears only after a reset pulse has ended.
- R4: While the timer is on, writing the full 32-bit word 0x00000076 to offset 0xC reloads the count with 2^(BASE_EXP+t)-1, where t is the running select in bits [3:0] of the period word. Any other value written there is ignored.
- R5: While the timer is on, a write to the period word (offset 0x4) stores both selects and also acts as a restart, loading the count from the newly written running select.
- R6: The count, read at offset 0x8, drops by one on every clock while the timer is on. Writes to offset 0x8 have no effect.
- R7: With control bit 1 clear (reset mode), the clock edge on which the count is found at zero starts a `sys_rst_o` pulse lasting exactly RST_CYC cycles.
- R8: With control bit 1 set (interrupt mode), the first expiry raises `irq_o` and reloads the count from the running select. A second expiry while `irq_o` is still high starts the reset pulse and clears `irq_o`.
- R9: A valid restart (R4 or R5) clears a pending `irq_o`.
- R10: After the reset pulse, the enable reads 0 and the count stays at 0. The timer cannot be turned on again until the block is reset.
- R11: A restart word written while the timer is off has no effect: the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register to read or write |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt, raised on the first expiry in interrupt mode |
| sys_rst_o | output | 1 | System reset pulse, RST_CYC cycles long |

## Verification
The bench goes after the edges of the restart filter: the exact word 0x76 against near misses such as 0x77 and 0x176. A filter that compared only the low byte would reload the count on 0x176, and the bench would see the count jump back up instead of dropping by one. It drives the enable bit through 0 after the timer is on and after a trip. An enable that is not sticky, or that can be set again after a trip, shows up in the control read-back and in a count that starts moving again. It times the expiry to the exact cycle in both response modes and counts the width of the reset pulse, so an off-by-one load value, a missing interrupt stage, or a pulse one cycle long or short each make a check fail. Random period selects and random restart times check the load values for both selects against a bench formula.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int SEL_W  = 4;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RANGE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_KICK  = 4'hC;

    // The only restart word accepted
    localparam logic [DATA_W-1:0] KICK_WORD = 32'h0000_0076;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PULSE = 2'd1,
        ST_DONE  = 2'd2
    } kwd_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } kwd_bus_t;

    typedef struct packed {
        logic             en;
        logic             irq_mode;
        logic [SEL_W-1:0] top;
        logic [SEL_W-1:0] top_init;
    } kwd_cfg_t;

    // Exponent of a period select: base + select
    function automatic int period_exp(input logic [SEL_W-1:0] sel, input int base);
        return base + int'(sel);
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  kwd_bus_t          bus,
    input  logic              running,
    input  logic              done,
    input  logic [CNT_W-1:0]  count,
    output kwd_cfg_t          cfg,
    output logic              start,
    output logic              kick,
    output logic [SEL_W-1:0]  kick_sel,
    output logic [DATA_W-1:0] rdata
);

    logic wr_ctrl;
    logic wr_range;
    logic wr_kick;
    logic magic_hit;

    assign wr_ctrl   = bus.we && (bus.addr == OFS_CTRL);
    assign wr_range  = bus.we && (bus.addr == OFS_RANGE);
    assign wr_kick   = bus.we && (bus.addr == OFS_KICK);
    assign magic_hit = (bus.wdata == KICK_WORD);

    // Turn-on only from off, and never after a trip
    assign start = wr_ctrl && bus.wdata[0] && !cfg.en && running;

    // Restart: the exact word, or any write of the period register
    assign kick = cfg.en && running && (wr_range || (wr_kick && magic_hit));

    // A period write restarts from the value being written
    assign kick_sel = wr_range ? bus.wdata[SEL_W-1:0] : cfg.top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.irq_mode <= bus.wdata[1];
            end
            if (start) begin
                cfg.en <= 1'b1;
            end
            if (done) begin
                cfg.en <= 1'b0;
            end
            if (wr_range) begin
                cfg.top      <= bus.wdata[SEL_W-1:0];
                cfg.top_init <= bus.wdata[2*SEL_W-1:SEL_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (bus.addr)
            OFS_CTRL:  rdata = DATA_W'({cfg.irq_mode, cfg.en});
            OFS_RANGE: rdata = DATA_W'({cfg.top_init, cfg.top});
            OFS_COUNT: rdata = DATA_W'(count);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             kick,
    input  logic             reload,
    input  logic [SEL_W-1:0] init_sel,
    input  logic [SEL_W-1:0] kick_sel,
    input  logic [SEL_W-1:0] top_sel,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] load_of(input logic [SEL_W-1:0] sel);
        return (ONE << period_exp(sel, BASE_EXP)) - ONE;
    endfunction

    // A restart on the same edge wins over expiry
    assign expire = run && (count == '0) && !kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (start) begin
            count <= load_of(init_sel);
        end else if (kick) begin
            count <= load_of(kick_sel);
        end else if (reload) begin
            count <= load_of(top_sel);
        end else if (run && (count != '0)) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/kwd_resp.sv
module kwd_resp
    import kwd_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic kick,
    input  logic irq_mode,
    output logic irq,
    output logic sys_rst,
    output logic reload,
    output logic running,
    output logic done
);

    localparam int PW = $clog2(RST_CYC + 1);

    kwd_state_e    state;
    logic [PW-1:0] pcnt;

    // First expiry in interrupt mode reloads instead of tripping
    assign reload  = expire && irq_mode && !irq;
    assign sys_rst = (state == ST_PULSE);
    assign running = (state == ST_RUN);
    assign done    = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            irq   <= 1'b0;
            pcnt  <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (kick) begin
                        irq <= 1'b0;
                    end
                    if (expire) begin
                        if (irq_mode && !irq) begin
                            irq <= 1'b1;
                        end else begin
                            state <= ST_PULSE;
                            irq   <= 1'b0;
                            pcnt  <= '0;
                        end
                    end
                end
                ST_PULSE: begin
                    if (pcnt == PW'(RST_CYC - 1)) begin
                        state <= ST_DONE;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                default: begin
                    state <= ST_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
    import kwd_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int RST_CYC  = 8,
    localparam int CNT_W   = BASE_EXP + 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    kwd_bus_t         bus;
    kwd_cfg_t         cfg;
    logic             start;
    logic             kick;
    logic [SEL_W-1:0] kick_sel;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             reload;
    logic             running;
    logic             done;
    logic             run;

    assign bus = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign run = cfg.en && running;

    kwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .running  (running),
        .done     (done),
        .count    (count),
        .cfg      (cfg),
        .start    (start),
        .kick     (kick),
        .kick_sel (kick_sel),
        .rdata    (bus_rdata)
    );

    kwd_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .start    (start),
        .kick     (kick),
        .reload   (reload),
        .init_sel (cfg.top_init),
        .kick_sel (kick_sel),
        .top_sel  (cfg.top),
        .count    (count),
        .expire   (expire)
    );

    kwd_resp #(.RST_CYC(RST_CYC)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .kick     (kick),
        .irq_mode (cfg.irq_mode),
        .irq      (irq_o),
        .sys_rst  (sys_rst_o),
        .reload   (reload),
        .running  (running),
        .done     (done)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              en,
    input logic              irq_mode,
    input logic              run,
    input logic              done,
    input logic [CNT_W-1:0]  count
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (sys_rst_o) begin
            hi_cnt <= hi_cnt + 16'd1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R7: pulse never exceeds, and ends at, RST_CYC cycles
    p_pulse_max_r7: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (hi_cnt < 16'(RST_CYC)));
    p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> (hi_cnt == 16'(RST_CYC)));

    // R6: count falls by one per cycle while running and the bus is quiet
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (run && (count != '0) && !bus_we) |=> (count == $past(count) - CNT_W'(1)));

    // R3: enable falls only once the trip has completed
    p_sticky_en_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> done);

    // R10: after the trip the enable stays clear
    p_stay_off_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !en);

    // R8: in interrupt mode a reset pulse is preceded by a pending interrupt
    p_irq_first_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(sys_rst_o) && $past(irq_mode)) |-> $past(irq_o));

    // R8: interrupt and reset pulse never overlap
    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(irq_o && sys_rst_o));

    // R9: the exact restart word clears a pending interrupt
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_KICK) && (bus_wdata == KICK_WORD) && irq_o) |=> !irq_o);

endmodule

bind kick_watchdog kwd_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (cfg.en),
    .irq_mode  (cfg.irq_mode),
    .run       (run),
    .done      (done),
    .count     (count)
);

// File: tb/sim_kick_watchdog.sv
`timescale 1ns/1ps
module sim_kick_watchdog;

    localparam int BASE = 2;
    localparam int PULSE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    kick_watchdog #(.BASE_EXP(BASE), .RST_CYC(PULSE)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    // Count value right after a load with select s
    function automatic int unsigned load_val(input int s);
        return (32'd1 << (BASE + s)) - 1;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(irq_o, 0, "R1 irq");
        chk(sys_rst_o, 0, "R1 sys_rst");
        rd(4'h0, v); chk(v, 0, "R1 ctrl");
        rd(4'h4, v); chk(v, 0, "R1 range");
        rd(4'h8, v); chk(v, 0, "R1 count");

        // R11 restart while off
        wr(4'hC, 32'h76);
        rd(4'h8, v); chk(v, 0, "R11 count stays 0");

        // R2 turn-on load from initial select 0
        wr(4'h4, 32'h01);
        wr(4'h0, 32'h1);
        rd(4'h8, v); chk(v, load_val(0), "R2 initial load");
        tick(1);
        rd(4'h8, v); chk(v, load_val(0) - 1, "R6 decrement");
        // R4 exact word reloads from running select
        wr(4'hC, 32'h76);
        rd(4'h8, v); chk(v, load_val(1), "R4 restart");
        tick(2);
        wr(4'hC, 32'h77);
        rd(4'h8, v); chk(v, load_val(1) - 3, "R4 0x77 ignored");
        wr(4'hC, 32'h176);
        rd(4'h8, v); chk(v, load_val(1) - 4, "R4 0x176 ignored");
        // R3 sticky enable
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk(v[0], 1, "R3 enable sticky");
        rd(4'h8, v); chk(v, load_val(1) - 5, "R3 still counting");
        wr(4'hC, 32'h76);
        wr(4'h8, 32'h0);
        rd(4'h8, v); chk(v, load_val(1) - 1, "R6 write to count ignored");
        rd(4'h4, v); chk(v, 32'h01, "R5 range readback");
        // R7 expiry in reset mode
        tick(load_val(1) - 1);
        chk(sys_rst_o, 0, "R7 no pulse before expiry");
        rd(4'h8, v); chk(v, 0, "R7 count at zero");
        tick(1);
        chk(sys_rst_o, 1, "R7 pulse starts");
        chk(irq_o, 0, "R7 no irq in reset mode");
        for (int i = 1; i < PULSE; i++) begin
            tick(1);
            chk(sys_rst_o, 1, "R7 pulse held");
        end
        tick(1);
        chk(sys_rst_o, 0, "R7 pulse ends");
        tick(1);
        rd(4'h0, v); chk(v[0], 0, "R10 enable cleared");
        rd(4'h8, v); chk(v, 0, "R10 count zero");
        wr(4'h0, 32'h1);
        tick(3);
        rd(4'h0, v); chk(v[0], 0, "R10 cannot re-enable");
        rd(4'h8, v); chk(v, 0, "R10 count idle");
        chk(sys_rst_o, 0, "R10 no new pulse");

        // R5 period write restarts from new select
        do_reset();
        wr(4'h0, 32'h1);
        rd(4'h8, v); chk(v, load_val(0), "R2 default select");
        wr(4'h4, 32'h02);
        rd(4'h8, v); chk(v, load_val(2), "R5 range write restarts");

        // R2 initial select differs from running select
        do_reset();
        wr(4'h4, 32'h30);
        wr(4'h0, 32'h1);
        rd(4'h8, v); chk(v, load_val(3), "R2 initial select 3");
        wr(4'hC, 32'h76);
        rd(4'h8, v); chk(v, load_val(0), "R4 restart uses running select");

        // R8 / R9 interrupt mode
        do_reset();
        wr(4'h4, 32'h11);
        wr(4'h0, 32'h3);
        tick(load_val(1));
        chk(irq_o, 0, "R8 no irq before expiry");
        tick(1);
        chk(irq_o, 1, "R8 irq on first expiry");
        chk(sys_rst_o, 0, "R8 no pulse on first expiry");
        rd(4'h8, v); chk(v, load_val(1), "R8 reload on first expiry");
        wr(4'hC, 32'h76);
        chk(irq_o, 0, "R9 restart clears irq");
        rd(4'h8, v); chk(v, load_val(1), "R9 restart reload");
        tick(load_val(1) + 1);
        chk(irq_o, 1, "R8 irq again");
        tick(load_val(1));
        chk(sys_rst_o, 0, "R8 pulse not yet");
        tick(1);
        chk(sys_rst_o, 1, "R8 second expiry resets");
        chk(irq_o, 0, "R8 irq cleared at pulse");

        // Random selects, restart times and rejected words
        for (int t = 0; t < 20; t++) begin
            int si;
            int sr;
            int k;
            logic [31:0] bad;
            si = int'($urandom % 3);
            sr = int'($urandom % 3);
            do_reset();
            wr(4'h4, 32'((si << 4) | sr));
            wr(4'h0, 32'h1);
            k = int'($urandom % (load_val(si)));
            tick(k);
            rd(4'h8, v); chk(v, load_val(si) - k, "R2 random initial count");
            wr(4'hC, 32'h76);
            rd(4'h8, v); chk(v, load_val(sr), "R4 random restart");
            bad = $urandom;
            if (bad == 32'h76) bad = 32'h75;
            wr(4'hC, bad);
            rd(4'h8, v); chk(v, load_val(sr) - 1, "R4 random word ignored");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule